// File: doc/BRIEF.md
# Debounced Tamper Detector with Request Routing

This block watches an active-low tamper input, such as a chassis-open switch. The input is brought into the clock domain through a short synchronizer. A counter then measures how long the input stays asserted, in units of an external one-microsecond tick. If the input is held asserted without a break for more than 60 ticks, a sticky status bit is set. Any release before that point restarts the measurement from zero.

While the status bit is set, a two-bit route select steers it to one of two request outputs, interrupt or system-management. Code 01 selects the interrupt line and code 10 selects the system-management line. The other two codes are reserved and raise nothing. Software clears the status by pulsing the write-one-to-clear strobe.

After a clear, an input that is still held low does not set the status again. The input must first go inactive and then meet the full window a second time.

Top module: `tamper_watch`

## Requirements
- R1: After reset the status bit, the interrupt request and the system-management request are all 0.
- R2: The status bit sets on the 61st tick counted while the synchronized input is continuously low. It stays 0 through the first 60 such ticks. Ticks while the input is high have no effect.
- R3: A release of the input before the status sets discards the ticks counted so far. After the input is asserted again, 61 new ticks are needed.
- R4: Once set, the status bit stays 1 when the input is released and ticks continue.
- R5: A one-cycle pulse on `stat_clr` clears the status bit by the next clock edge. The pulse has no effect when the status is already 0.
- R6: With `route_sel` = 2'b01, `irq_req` equals the status bit and `smi_req` is 0.
- R7: With `route_sel` = 2'b10, `smi_req` equals the status bit and `irq_req` is 0.
- R8: With `route_sel` = 2'b00 or 2'b11, both requests are 0, and the status bit is unchanged.
- R9: After a clear while the input is still held low, the status stays 0 however many ticks follow. It sets again only after the input goes high and then completes a fresh 61-tick window.
- R10: When the qualifying tick and a `stat_clr` pulse fall in the same cycle, the set wins and the status bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| intr_pin_n | input | 1 | Raw active-low tamper input |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| route_sel | input | 2 | Request routing select: 01 interrupt, 10 system management, 00/11 reserved |
| intr_status | output | 1 | Sticky tamper status |
| irq_req | output | 1 | Interrupt request |
| smi_req | output | 1 | System-management request |

## Verification
The hardest case to reach from the ports is the collision of the qualifying tick with a clear strobe (R10). The bench reaches it in three steps:

- It holds the input low for exactly 60 ticks.
- It raises `us_tick` and `stat_clr` on the same falling edge.
- It samples the status one cycle later.

The re-arm case (R9) needs a clear while the counter is saturated with the input still low. To reach it, the bench leaves the input asserted after one set and clear, then keeps ticking well past the window before it releases the input.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

  typedef enum logic [1:0] {
    ROUTE_OFF  = 2'b00,
    ROUTE_IRQ  = 2'b01,
    ROUTE_SMI  = 2'b10,
    ROUTE_HOLD = 2'b11
  } route_e;

  // Request vector {smi, irq} for a given status and select code.
  function automatic logic [1:0] route_mask(input logic status, input logic [1:0] sel);
    logic [1:0] m;
    case (route_e'(sel))
      ROUTE_IRQ: m = 2'b01;
      ROUTE_SMI: m = 2'b10;
      default:   m = 2'b00;
    endcase
    return status ? m : 2'b00;
  endfunction

  // Next value of a counter that saturates one past its limit.
  function automatic int unsigned count_step(input int unsigned cnt, input int unsigned limit);
    return (cnt > limit) ? cnt : cnt + 1;
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_debounce.sv
module tw_debounce
  import tamper_pkg::*;
#(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic qual_evt
);
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (tick)    cnt <= CNT_W'(count_step(int'(cnt), LIMIT));
  end

  // Fires once per continuous assertion: the tick that moves past the limit.
  assign qual_evt = active && tick && (cnt == LIM_C);
endmodule

// File: rtl/tw_status.sv
module tw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  output logic status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= 1'b0;
    else if (set_evt) status <= 1'b1;
    else if (clr_wr)  status <= 1'b0;
  end
endmodule

// File: rtl/tw_route.sv
module tw_route
  import tamper_pkg::*;
(
  input  logic       status,
  input  logic [1:0] sel,
  output logic       irq,
  output logic       smi
);
  logic [1:0] req;
  assign req = route_mask(status, sel);
  assign irq = req[0];
  assign smi = req[1];
endmodule

// File: rtl/tamper_watch.sv
module tamper_watch #(
  parameter int DEBOUNCE_US = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       intr_pin_n,
  input  logic       stat_clr,
  input  logic [1:0] route_sel,
  output logic       intr_status,
  output logic       irq_req,
  output logic       smi_req
);
  logic pin_sync_n;
  logic pin_active;
  logic qual_evt;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(intr_pin_n), .q(pin_sync_n)
  );

  assign pin_active = ~pin_sync_n;

  tw_debounce #(.LIMIT(DEBOUNCE_US)) u_deb (
    .clk(clk), .rst_n(rst_n), .active(pin_active), .tick(us_tick), .qual_evt(qual_evt)
  );

  tw_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_evt(qual_evt), .clr_wr(stat_clr), .status(intr_status)
  );

  tw_route u_route (
    .status(intr_status), .sel(route_sel), .irq(irq_req), .smi(smi_req)
  );
endmodule

// File: rtl/tamper_watch_chk.sv
module tamper_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       qual_evt,
  input logic       stat_clr,
  input logic [1:0] route_sel,
  input logic       intr_status,
  input logic       irq_req,
  input logic       smi_req
);
  p_rise_needs_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_status) |-> $past(qual_evt));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_status && !stat_clr && !qual_evt) |=> intr_status);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !qual_evt) |=> !intr_status);

  p_irq_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (route_sel == 2'b01) |-> (irq_req == intr_status) && !smi_req);

  p_smi_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (route_sel == 2'b10) |-> (smi_req == intr_status) && !irq_req);

  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_sel == 2'b00 || route_sel == 2'b11) |-> !irq_req && !smi_req);

  p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |=> !qual_evt);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |=> intr_status);
endmodule

bind tamper_watch tamper_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .qual_evt(qual_evt), .stat_clr(stat_clr),
  .route_sel(route_sel), .intr_status(intr_status), .irq_req(irq_req), .smi_req(smi_req)
);

// File: tb/tamper_watch_tb.sv
module tamper_watch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       intr_pin_n = 1'b1;
  logic       stat_clr = 1'b0;
  logic [1:0] route_sel = 2'b01;
  logic       intr_status, irq_req, smi_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tamper_watch u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .intr_pin_n(intr_pin_n),
    .stat_clr(stat_clr), .route_sel(route_sel), .intr_status(intr_status),
    .irq_req(irq_req), .smi_req(smi_req)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
    end
  endtask

  task automatic set_pin(input logic level);
    @(negedge clk) intr_pin_n = level;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_status();
    @(negedge clk) stat_clr = 1'b1;
    @(negedge clk) stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "status after reset", intr_status, 1'b0);
    chk("R1", "irq after reset", irq_req, 1'b0);
    chk("R1", "smi after reset", smi_req, 1'b0);
    ticks(70);
    chk("R2", "ticks with pin high", intr_status, 1'b0);
  endtask

  task automatic t_window();
    route_sel = 2'b01;
    set_pin(1'b0);
    ticks(60);
    chk("R2", "status after 60 ticks", intr_status, 1'b0);
    chk("R6", "irq before set", irq_req, 1'b0);
    ticks(1);
    chk("R2", "status after 61 ticks", intr_status, 1'b1);
    chk("R6", "irq with sel 01", irq_req, 1'b1);
    chk("R6", "smi with sel 01", smi_req, 1'b0);
  endtask

  task automatic t_sticky();
    set_pin(1'b1);
    ticks(70);
    chk("R4", "status after release", intr_status, 1'b1);
  endtask

  task automatic t_routes();
    @(negedge clk) route_sel = 2'b10;
    @(negedge clk);
    chk("R7", "smi with sel 10", smi_req, 1'b1);
    chk("R7", "irq with sel 10", irq_req, 1'b0);
    @(negedge clk) route_sel = 2'b00;
    @(negedge clk);
    chk("R8", "irq with sel 00", irq_req, 1'b0);
    chk("R8", "smi with sel 00", smi_req, 1'b0);
    chk("R8", "status with sel 00", intr_status, 1'b1);
    @(negedge clk) route_sel = 2'b11;
    @(negedge clk);
    chk("R8", "irq with sel 11", irq_req, 1'b0);
    chk("R8", "smi with sel 11", smi_req, 1'b0);
    chk("R8", "status with sel 11", intr_status, 1'b1);
    @(negedge clk) route_sel = 2'b01;
  endtask

  task automatic t_clear();
    clear_status();
    chk("R5", "status after clear", intr_status, 1'b0);
    chk("R5", "irq after clear", irq_req, 1'b0);
    clear_status();
    chk("R5", "clear when already 0", intr_status, 1'b0);
  endtask

  task automatic t_restart();
    set_pin(1'b0);
    ticks(50);
    set_pin(1'b1);
    set_pin(1'b0);
    ticks(50);
    chk("R3", "status after 50+50 with break", intr_status, 1'b0);
    ticks(10);
    chk("R3", "status after 60 fresh ticks", intr_status, 1'b0);
    ticks(1);
    chk("R3", "status after 61 fresh ticks", intr_status, 1'b1);
    clear_status();
  endtask

  task automatic t_rearm();
    ticks(100);
    chk("R9", "status with pin still held", intr_status, 1'b0);
    set_pin(1'b1);
    set_pin(1'b0);
    ticks(60);
    chk("R9", "status after 60 rearm ticks", intr_status, 1'b0);
    ticks(1);
    chk("R9", "status after rearm window", intr_status, 1'b1);
    clear_status();
    set_pin(1'b1);
  endtask

  task automatic t_collide();
    set_pin(1'b0);
    ticks(60);
    @(negedge clk) begin us_tick = 1'b1; stat_clr = 1'b1; end
    @(negedge clk) begin us_tick = 1'b0; stat_clr = 1'b0; end
    chk("R10", "set beats same-cycle clear", intr_status, 1'b1);
    clear_status();
    chk("R10", "later clear still works", intr_status, 1'b0);
    set_pin(1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_sticky();
    t_routes();
    t_clear();
    t_restart();
    t_rearm();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule